// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller that sits beside a successive-approximation converter. It derives a slow converter tick from the system clock through a programmable divider. Out of reset it runs a fixed power-up calibration. After that it waits for a one-cycle start request. For each request it runs a sample phase, then resolves the code one bit per tick, then spends a short slot on post-calibration. At the end it publishes the code together with the channel that was requested.

The analog side is abstracted. The block presents its trial code on `dac_code_o`, and the comparator answers on `comp_i`, high when the held input is at or above the trial code. Software or a wrapper supplies the divider value, the sample-time value, the channel number and a 4-bit mode word on plain inputs.

Top module: `sar_seq`

## Requirements
- R1: The converter tick occurs once every 4 × (`tvc_i` + 1) system clocks. A free-running counter that starts at reset sets its phase, and the divider value is read live.
- R2: After reset `calib_o` is high. It falls at the system clock edge that carries the 3,840th tick after reset and never rises again until the next reset.
- R3: A start accepted while idle (`busy_o` and `calib_o` low) raises `sample_o` and `busy_o` together on the next cycle and clears `dvalid_o`. The same start captures `chan_i`, `stc_i` and `mode_i`. Later changes to `chan_i`, `stc_i` and `mode_i` do not affect that conversion.
- R4: `sample_o` falls on the (`stc_i` + 2)-th tick after acceptance, and `busy_o` stays high.
- R5: Conversion resolves one bit per tick, MSB first. On entry, `dac_code_o` holds only the MSB set. At each tick the bit under test keeps the value of `comp_i`, and the next lower bit is set to 1.
- R6: Mode bits [1:0] select the resolution: 00 gives 10 bits, 01 gives 12 bits, 10 gives 8 bits, 11 gives 12 bits. The result is right-justified in `result_o`, with the upper bits zero.
- R7: After the last bit there is a post-calibration slot of 2 ticks. During it `pcal_o` and `busy_o` are high and `sample_o` is low. `pcal_tgt_o` names the target: 0 means offset, and k means array bit k−1. The target advances by one at the end of each slot and wraps from 12 to 0.
- R8: At the end of the slot `busy_o` falls. In the same cycle `dvalid_o` rises, and `result_o` and `chan_o` are updated. They hold until the next accepted start.
- R9: `cmp_pd_o` is high while idle after a conversion whose captured mode bit 2 was 0. It is low otherwise, and it is cleared by the next accepted start.
- R10: A start pulse while `busy_o` or `calib_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 5 | Channel number to convert |
| tvc_i | input | 8 | Tick divider value |
| stc_i | input | 8 | Sample-phase length value |
| mode_i | input | 4 | [1:0] resolution, [2] keep comparator powered |
| comp_i | input | 1 | Comparator decision for the current trial code |
| dac_code_o | output | 12 | Trial code driven to the capacitor array |
| sample_o | output | 1 | Sample phase active |
| busy_o | output | 1 | Conversion in progress |
| calib_o | output | 1 | Power-up calibration active |
| pcal_o | output | 1 | Post-calibration slot active |
| pcal_tgt_o | output | 4 | Post-calibration target index |
| dvalid_o | output | 1 | Result valid |
| result_o | output | 12 | Converted code |
| chan_o | output | 5 | Channel of the published result |
| cmp_pd_o | output | 1 | Comparator power-down request |

## Verification
A miscounted divider or phase counter shows up within one tick as a `sample_o`, `pcal_o` or `calib_o` edge in the wrong cycle. The cycle-by-cycle model catches such an edge at once. A corrupted bit index or trial register shows on `dac_code_o` at the next tick, and in `result_o` at the end of the conversion, where it is compared against the ideal input value. A round-robin pointer that drifts shows in `pcal_tgt_o` during the next slot.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_CAL  = 3'd0,
    ST_IDLE = 3'd1,
    ST_SAMP = 3'd2,
    ST_CONV = 3'd3,
    ST_PCAL = 3'd4
  } seq_state_t;

  // resolution in bits selected by mode[1:0], clamped to the datapath width
  function automatic int unsigned res_bits(input logic [1:0] m, input int unsigned width);
    int unsigned n;
    case (m)
      2'b00:   n = 10;
      2'b10:   n = 8;
      default: n = 12;
    endcase
    return (n > width) ? width : n;
  endfunction
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] tvc_i,
  output logic             tick
);
  localparam int CW = PRE_W + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  // period is 4*(tvc+1): terminal count is tvc*4+3
  assign limit = {tvc_i, 2'b11};
  assign tick  = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt >= limit) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_pcal_rr.sv
module sar_pcal_rr #(
  parameter int RES_W = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  output logic [$clog2(RES_W+1)-1:0]   tgt
);
  localparam int TG_W = $clog2(RES_W + 1);
  localparam logic [TG_W-1:0] LAST = TG_W'(RES_W);

  always_ff @(posedge clk) begin
    if (rst)      tgt <= '0;
    else if (adv) tgt <= (tgt == LAST) ? '0 : tgt + 1'b1;
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int CH_W    = 5,
  parameter int STC_W   = 8,
  parameter int MODE_W  = 4,
  parameter int CAL_CYC = 3840,
  parameter int PCAL_TK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [STC_W-1:0]  stc_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              comp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              calib_o,
  output logic              pcal_o,
  output logic              rr_adv,
  output logic              dvalid_o,
  output logic [RES_W-1:0]  result_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              cmp_pd_o
);
  localparam int CAL_W = $clog2(CAL_CYC);
  localparam int TC_W  = (CAL_W > STC_W + 1) ? CAL_W : STC_W + 1;
  localparam int BI_W  = $clog2(RES_W);

  seq_state_t        state, nxt;
  logic [TC_W-1:0]   tcnt;
  logic [BI_W-1:0]   bidx;
  logic [RES_W-1:0]  sar;
  logic [CH_W-1:0]   chan_q;
  logic [STC_W-1:0]  stc_q;
  logic [MODE_W-1:0] mode_q;
  int unsigned       nb;

  assign nb         = res_bits(mode_q[1:0], RES_W);
  assign dac_code_o = sar;
  assign rr_adv     = (state == ST_PCAL) && (nxt == ST_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      ST_CAL:  if (tick && tcnt == TC_W'(CAL_CYC - 1)) nxt = ST_IDLE;
      ST_IDLE: if (start_i) nxt = ST_SAMP;
      ST_SAMP: if (tick && tcnt == TC_W'(stc_q) + TC_W'(1)) nxt = ST_CONV;
      ST_CONV: if (tick && bidx == '0) nxt = ST_PCAL;
      ST_PCAL: if (tick && tcnt == TC_W'(PCAL_TK - 1)) nxt = ST_IDLE;
      default: nxt = ST_CAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CAL;
      tcnt     <= '0;
      bidx     <= '0;
      sar      <= '0;
      chan_q   <= '0;
      stc_q    <= '0;
      mode_q   <= '0;
      sample_o <= 1'b0;
      busy_o   <= 1'b0;
      calib_o  <= 1'b1;
      pcal_o   <= 1'b0;
      dvalid_o <= 1'b0;
      result_o <= '0;
      chan_o   <= '0;
      cmp_pd_o <= 1'b0;
    end else begin
      state    <= nxt;
      sample_o <= (nxt == ST_SAMP);
      busy_o   <= (nxt == ST_SAMP) || (nxt == ST_CONV) || (nxt == ST_PCAL);
      calib_o  <= (nxt == ST_CAL);
      pcal_o   <= (nxt == ST_PCAL);
      if (nxt != state) tcnt <= '0;
      else if (tick)    tcnt <= tcnt + 1'b1;
      case (state)
        ST_IDLE: if (start_i) begin
          chan_q   <= chan_i;
          stc_q    <= stc_i;
          mode_q   <= mode_i;
          dvalid_o <= 1'b0;
          cmp_pd_o <= 1'b0;
        end
        ST_SAMP: if (nxt == ST_CONV) begin
          sar  <= RES_W'(1) << (nb - 1);
          bidx <= BI_W'(nb - 1);
        end
        ST_CONV: if (tick) begin
          sar[bidx] <= comp_i;
          if (bidx != '0) begin
            sar[bidx - 1'b1] <= 1'b1;
            bidx             <= bidx - 1'b1;
          end
        end
        ST_PCAL: if (nxt == ST_IDLE) begin
          result_o <= sar;
          chan_o   <= chan_q;
          dvalid_o <= 1'b1;
          cmp_pd_o <= ~mode_q[2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int PRE_W   = 8,
  parameter int STC_W   = 8,
  parameter int MODE_W  = 4,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12,
  parameter int CAL_CYC = 3840,
  parameter int PCAL_TK = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [CH_W-1:0]            chan_i,
  input  logic [PRE_W-1:0]           tvc_i,
  input  logic [STC_W-1:0]           stc_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic                       comp_i,
  output logic [RES_W-1:0]           dac_code_o,
  output logic                       sample_o,
  output logic                       busy_o,
  output logic                       calib_o,
  output logic                       pcal_o,
  output logic [$clog2(RES_W+1)-1:0] pcal_tgt_o,
  output logic                       dvalid_o,
  output logic [RES_W-1:0]           result_o,
  output logic [CH_W-1:0]            chan_o,
  output logic                       cmp_pd_o
);
  logic tick;
  logic rr_adv;

  sar_clkdiv #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst(rst), .tvc_i(tvc_i), .tick(tick)
  );

  sar_ctrl #(
    .RES_W(RES_W), .CH_W(CH_W), .STC_W(STC_W), .MODE_W(MODE_W),
    .CAL_CYC(CAL_CYC), .PCAL_TK(PCAL_TK)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .start_i(start_i),
    .chan_i(chan_i), .stc_i(stc_i), .mode_i(mode_i), .comp_i(comp_i),
    .dac_code_o(dac_code_o), .sample_o(sample_o), .busy_o(busy_o),
    .calib_o(calib_o), .pcal_o(pcal_o), .rr_adv(rr_adv),
    .dvalid_o(dvalid_o), .result_o(result_o), .chan_o(chan_o),
    .cmp_pd_o(cmp_pd_o)
  );

  sar_pcal_rr #(.RES_W(RES_W)) u_rr (
    .clk(clk), .rst(rst), .adv(rr_adv), .tgt(pcal_tgt_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_o,
  input logic                       busy_o,
  input logic                       calib_o,
  input logic                       pcal_o,
  input logic                       dvalid_o,
  input logic [RES_W-1:0]           result_o,
  input logic [$clog2(RES_W+1)-1:0] pcal_tgt_o
);
  a_r3_rise_together: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $rose(sample_o));

  a_r4_sample_in_busy: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> busy_o);

  a_r2_cal_no_return: assert property (@(posedge clk) disable iff (rst)
    !calib_o |=> !calib_o);

  a_r10_idle_in_cal: assert property (@(posedge clk) disable iff (rst)
    calib_o |-> !busy_o);

  a_r7_pcal_in_busy: assert property (@(posedge clk) disable iff (rst)
    pcal_o |-> (busy_o && !sample_o));

  a_r7_tgt_range: assert property (@(posedge clk) disable iff (rst)
    pcal_tgt_o <= ($clog2(RES_W+1))'(RES_W));

  a_r8_valid_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> dvalid_o);

  a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
    (dvalid_o && $past(dvalid_o)) |-> $stable(result_o));
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .sample_o(sample_o), .busy_o(busy_o),
  .calib_o(calib_o), .pcal_o(pcal_o), .dvalid_o(dvalid_o),
  .result_o(result_o), .pcal_tgt_o(pcal_tgt_o)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [4:0]  chan_i = '0;
  logic [7:0]  tvc_i = '0;
  logic [7:0]  stc_i = '0;
  logic [3:0]  mode_i = '0;
  logic        comp_i;
  logic [11:0] dac_code_o;
  logic        sample_o, busy_o, calib_o, pcal_o, dvalid_o, cmp_pd_o;
  logic [3:0]  pcal_tgt_o;
  logic [11:0] result_o;
  logic [4:0]  chan_o;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int nconv = 0;

  always #2.5 clk = ~clk;

  assign comp_i = (vin >= int'(dac_code_o));

  sar_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .tvc_i(tvc_i),
    .stc_i(stc_i), .mode_i(mode_i), .comp_i(comp_i), .dac_code_o(dac_code_o),
    .sample_o(sample_o), .busy_o(busy_o), .calib_o(calib_o), .pcal_o(pcal_o),
    .pcal_tgt_o(pcal_tgt_o), .dvalid_o(dvalid_o), .result_o(result_o),
    .chan_o(chan_o), .cmp_pd_o(cmp_pd_o)
  );

  // behavioural reference: 0 cal, 1 idle, 2 sample, 3 convert, 4 post-cal
  int m_div, m_st, m_tc, m_bit, m_code, m_res, m_chq, m_ch, m_stc, m_mode, m_rr;
  bit m_dv, m_pd;

  function automatic int nbits(input int md);
    case (md & 3)
      0: return 10;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_st = 0; m_tc = 0; m_bit = 0; m_code = 0; m_res = 0;
      m_chq = 0; m_ch = 0; m_stc = 0; m_mode = 0; m_rr = 0; m_dv = 0; m_pd = 0;
    end else begin
      int per;
      bit tk;
      per = 4 * (int'(tvc_i) + 1);
      tk = (m_div == per - 1);
      m_div = (m_div >= per - 1) ? 0 : m_div + 1;
      case (m_st)
        0: if (tk) begin
          if (m_tc == 3839) begin m_st = 1; m_tc = 0; end else m_tc++;
        end
        1: if (start_i) begin
          m_st = 2; m_tc = 0; m_chq = chan_i; m_stc = stc_i; m_mode = mode_i;
          m_dv = 0; m_pd = 0;
        end
        2: if (tk) begin
          if (m_tc == m_stc + 1) begin
            m_st = 3; m_tc = 0; m_bit = nbits(m_mode) - 1; m_code = 1 << m_bit;
          end else m_tc++;
        end
        3: if (tk) begin
          if (!(vin >= m_code)) m_code -= (1 << m_bit);
          if (m_bit == 0) begin m_st = 4; m_tc = 0; end
          else begin m_bit--; m_code += (1 << m_bit); end
        end
        4: if (tk) begin
          if (m_tc == 1) begin
            m_st = 1; m_res = m_code; m_ch = m_chq; m_dv = 1;
            m_pd = ((m_mode & 4) == 0); m_rr = (m_rr == 12) ? 0 : m_rr + 1;
          end else m_tc++;
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "calib", calib_o, m_st == 0);
      chk("R3", "busy", busy_o, m_st >= 2);
      chk("R4", "sample", sample_o, m_st == 2);
      chk("R5", "dac_code", dac_code_o, m_code);
      chk("R7", "pcal", pcal_o, m_st == 4);
      chk("R7", "pcal_tgt", pcal_tgt_o, m_rr);
      chk("R8", "dvalid", dvalid_o, m_dv);
      chk("R8", "result", result_o, m_res);
      chk("R8", "chan", chan_o, m_ch);
      chk("R9", "cmp_pd", cmp_pd_o, m_pd);
    end
  end

  task automatic run_conv(input int ch, input int md, input int st, input int v, input bit poke);
    @(negedge clk);
    vin = v; chan_i = 5'(ch); mode_i = 4'(md); stc_i = 8'(st); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R3", "sample rise", sample_o, 1);
    chk("R3", "dvalid cleared", dvalid_o, 0);
    chan_i = 5'(~ch); stc_i = 8'd40; mode_i = 4'(md ^ 3);   // R3 captured values hold
    if (poke) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;                                       // R10 start while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!dvalid_o) @(negedge clk);
    nconv++;
    chk("R6", "result value", result_o, v);
    chk("R3", "channel", chan_o, ch);
    chk("R7", "rotation", pcal_tgt_o, nconv % 13);
    chk("R9", "power-down", cmp_pd_o, (md & 4) == 0);
    repeat (3) @(negedge clk);
    chk("R10", "idle after poke", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ncal;
    repeat (3) @(negedge clk);
    chk("R2", "reset calib", calib_o, 1);
    chk("R8", "reset dvalid", dvalid_o, 0);
    chk("R3", "reset busy", busy_o, 0);
    rst = 1'b0;
    ncal = 0;
    @(negedge clk);
    while (calib_o) begin
      ncal++;
      if (ncal == 500) begin
        start_i = 1'b1;                                     // R10 start during calibration
        @(negedge clk);
        start_i = 1'b0;
        ncal++;
        chk("R10", "no busy in cal", busy_o, 0);
      end
      @(negedge clk);
    end
    chk("R2", "calibration length", ncal, 4 * 3840 - 1);
    run_conv(3, 4'b0100, 3, 700, 0);   // R6 10-bit
    run_conv(7, 4'b0001, 0, 4095, 0);  // R6 12-bit full scale
    run_conv(1, 4'b0010, 5, 0, 1);     // R6 8-bit zero, R10 poke
    run_conv(31, 4'b0111, 1, 2730, 0); // R6 mode 11
    tvc_i = 8'd2;                      // R1 slower tick
    run_conv(12, 4'b0000, 2, 513, 1);
    tvc_i = 8'd0;
    for (int i = 0; i < 10; i++)       // R7 wrap of the rotation
      run_conv(i, 4'b0110, i % 3, 17 * i + 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule